// File: doc/BRIEF.md
# Hibernation Wake and Power Controller

This block sits in the always-on domain of a chip. It turns off the main supply regulator when software asks for it, and it turns the regulator back on when an armed wake event arrives. Software reaches the block through a request stream for reads and writes. The block holds a control word, an interrupt mask, a raw event register and a masked view of it. It also holds 64 words of 32-bit scratch storage, which survives the powered-down period. After power returns, software reads the raw events and the scratch storage. From them it can tell a wake from a cold boot.

Three event inputs feed the block: an asynchronous wake pin, a one-cycle RTC match pulse and a low-battery level. It drives three outputs: a regulator-disable line, one combined interrupt request and a clock-source select. Every write is followed by a busy window that lasts a fixed number of slow-clock ticks. This window models the settling time of the slow domain, and any write that arrives inside it is dropped.

The request side has valid and ready signals. Ready is always high, so the block never back-pressures. An accepted read returns its data with `rd_valid` exactly one cycle later. The response has no ready, so the requester must accept it in that cycle.

Top module: `hib_ctrl`

## Requirements
- R1: After power-on reset, `reg_off`, `irq` and `clk_sel` are 0 and the raw event register (address 2) reads 0.
- R2: The 64 storage words at addresses 64..127 can each be written and read back. Their contents survive hibernation and main-domain reset.
- R3: A write to the control word (address 0) with bit 0 (hibernate) set and at least one wake enable set (bit 1 for RTC, bit 3 for the pin) drives `reg_off` to 1 on the next cycle.
- R4: A hibernate write with both wake enables clear is ignored: `reg_off` stays 0 and control bit 0 reads back as 0.
- R5: While hibernating with the pin enable set, a rising edge on the wake pin drives `reg_off` to 0 and clears control bit 0. Raw bit 2 stays set afterwards.
- R6: While hibernating with only the RTC enable set, an RTC match drives `reg_off` to 0 and a pin edge does not. With only the pin enable set, an RTC match does not wake the block.
- R7: Raw bit 0 records an RTC match, bit 1 records low battery and bit 2 records a wake-pin rising edge, whatever the enables are. The pin passes through a two-flop synchronizer. A pin held high sets bit 2 only once.
- R8: The masked register (address 3) reads raw AND mask (mask at address 1, bits 2:0). `irq` is the OR of the masked bits.
- R9: Writing the clear register (address 4) clears each raw bit whose written bit is 1. Written 0 bits leave their raw bits unchanged.
- R10: Control bit 2 drives `clk_sel`: 1 selects the 32.768 kHz oscillator and 0 selects the 4.194304 MHz crystal.
- R11: A write accepted while an earlier write is still inside its busy window of WRITE_TICKS slow ticks is dropped.
- R12: Main-domain reset (`sys_rst_n` low) clears the mask. It leaves the storage, the raw events and the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on fast clock |
| por_n | input | 1 | Power-on reset for the block, active low |
| sys_rst_n | input | 1 | Main-domain reset, active low, synchronous |
| slow_tick | input | 1 | One-cycle enable for each slow-clock period |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 7 | Word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 32 | Read data |
| wake_pin | input | 1 | External wake pin, asynchronous, active high |
| rtc_match | input | 1 | RTC match pulse |
| low_batt | input | 1 | Low-battery flag |
| reg_off | output | 1 | Regulator disable |
| irq | output | 1 | Combined interrupt request |
| clk_sel | output | 1 | Clock-source select |

## Verification
The bench builds the block with WRITE_TICKS set to 3 and a slow tick every fourth clock. A busy window then closes within about a dozen cycles. This lets the bench reach, in a short run, both a write dropped inside the window and writes accepted after it. MEM_WORDS stays at 64, so the bench can reach the first and the last storage word through the normal address decode.

// File: rtl/hib_pkg.sv
package hib_pkg;
  localparam int REG_CTRL = 0;
  localparam int REG_MASK = 1;
  localparam int REG_RAW  = 2;
  localparam int REG_MIS  = 3;
  localparam int REG_CLR  = 4;
  localparam int EV_W     = 3;
  localparam int EV_RTC   = 0;
  localparam int EV_BATT  = 1;
  localparam int EV_PIN   = 2;
endpackage

// File: rtl/hib_wake_sync.sv
module hib_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_async,
  output logic pin_rise
);
  logic [STAGES:0] chain_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], pin_async};
  end
  assign pin_rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/hib_wr_gate.sv
module hib_wr_gate #(
  parameter int WRITE_TICKS = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_n,
  input  logic slow_tick,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WRITE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WRITE_TICKS - 1);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!sys_rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy && start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy && slow_tick) begin
      if (cnt_q == LAST) busy <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hib_retmem.sv
module hib_retmem #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] store [WORDS];
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter int MEM_WORDS   = 64,
  parameter int DATA_W      = 32,
  parameter int WRITE_TICKS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int MEM_AW     = $clog2(MEM_WORDS),
  localparam int ADDR_W     = MEM_AW + 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              slow_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wake_pin,
  input  logic              rtc_match,
  input  logic              low_batt,
  output logic              reg_off,
  output logic              irq,
  output logic              clk_sel
);
  logic busy, pin_edge, wr_fire, rd_fire, mem_sel;
  logic hib_q, rtc_en_q, pin_en_q, clk_sel_q;
  logic [EV_W-1:0] raw_q, mask_q, mis, events, clr_bits;
  logic [DATA_W-1:0] mem_rdata, reg_rdata_q;
  logic rd_mem_q, wake_hit;

  assign req_ready = 1'b1;
  assign mem_sel   = req_addr[ADDR_W-1];
  assign wr_fire   = req_valid & req_write & ~busy;
  assign rd_fire   = req_valid & ~req_write;

  hib_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .pin_async(wake_pin), .pin_rise(pin_edge));

  hib_wr_gate #(.WRITE_TICKS(WRITE_TICKS)) u_gate (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .slow_tick(slow_tick),
    .start(req_valid & req_write), .busy(busy));

  hib_retmem #(.WORDS(MEM_WORDS), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(wr_fire & mem_sel), .waddr(req_addr[MEM_AW-1:0]),
    .wdata(req_wdata), .raddr(req_addr[MEM_AW-1:0]), .rdata(mem_rdata));

  // Control word: bit0 hibernate, bit1 RTC wake enable, bit2 clock select, bit3 pin wake enable.
  assign wake_hit = hib_q & ((pin_edge & pin_en_q) | (rtc_match & rtc_en_q));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hib_q <= 1'b0; rtc_en_q <= 1'b0; pin_en_q <= 1'b0; clk_sel_q <= 1'b0;
    end else if (wr_fire && !mem_sel && req_addr == ADDR_W'(REG_CTRL)) begin
      rtc_en_q  <= req_wdata[1];
      clk_sel_q <= req_wdata[2];
      pin_en_q  <= req_wdata[3];
      hib_q     <= req_wdata[0] & (req_wdata[1] | req_wdata[3]);
    end else if (wake_hit) begin
      hib_q <= 1'b0;
    end
  end

  assign events[EV_RTC]  = rtc_match;
  assign events[EV_BATT] = low_batt;
  assign events[EV_PIN]  = pin_edge;
  assign clr_bits = (wr_fire && !mem_sel && req_addr == ADDR_W'(REG_CLR))
                    ? req_wdata[EV_W-1:0] : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_bits) | events;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                               mask_q <= '0;
    else if (!sys_rst_n)                                      mask_q <= '0;
    else if (wr_fire && !mem_sel && req_addr == ADDR_W'(REG_MASK)) mask_q <= req_wdata[EV_W-1:0];
  end

  assign mis = raw_q & mask_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid <= 1'b0; rd_mem_q <= 1'b0; reg_rdata_q <= '0;
    end else if (!sys_rst_n) begin
      rd_valid <= 1'b0; rd_mem_q <= 1'b0; reg_rdata_q <= '0;
    end else begin
      rd_valid <= rd_fire;
      rd_mem_q <= mem_sel;
      reg_rdata_q <= '0;
      case (req_addr)
        ADDR_W'(REG_CTRL): reg_rdata_q[3:0] <= {pin_en_q, clk_sel_q, rtc_en_q, hib_q};
        ADDR_W'(REG_MASK): reg_rdata_q[EV_W-1:0] <= mask_q;
        ADDR_W'(REG_RAW):  reg_rdata_q[EV_W-1:0] <= raw_q;
        ADDR_W'(REG_MIS):  reg_rdata_q[EV_W-1:0] <= mis;
        default:           reg_rdata_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_mem_q ? mem_rdata : reg_rdata_q;
  assign reg_off = hib_q;
  assign irq     = |mis;
  assign clk_sel = clk_sel_q;
endmodule

// File: rtl/hib_ctrl_chk.sv
module hib_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       reg_off,
  input logic       irq,
  input logic       clk_sel,
  input logic       rtc_en_q,
  input logic       pin_en_q,
  input logic       pin_edge,
  input logic       rtc_match,
  input logic       wr_fire,
  input logic       mem_sel,
  input logic [6:0] req_addr,
  input logic [31:0] req_wdata,
  input logic [2:0] raw_q,
  input logic [2:0] mask_q
);
  p_arm_needs_src_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reg_off) |-> (rtc_en_q | pin_en_q));
  p_pin_wake_r5: assert property (@(posedge clk) disable iff (!por_n)
    (reg_off && pin_en_q && pin_edge) |=> !reg_off);
  p_rtc_wake_r6: assert property (@(posedge clk) disable iff (!por_n)
    (reg_off && rtc_en_q && rtc_match) |=> !reg_off);
  p_pin_raw_r7: assert property (@(posedge clk) disable iff (!por_n)
    pin_edge |=> raw_q[2]);
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> (mask_q != 3'b000 && raw_q != 3'b000));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_fire && !mem_sel && req_addr == 7'd4) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
  p_clk_sel_r10: assert property (@(posedge clk) disable iff (!por_n)
    (wr_fire && !mem_sel && req_addr == 7'd0) |=> (clk_sel == $past(req_wdata[2])));
endmodule

bind hib_ctrl hib_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .reg_off(reg_off), .irq(irq), .clk_sel(clk_sel),
  .rtc_en_q(rtc_en_q), .pin_en_q(pin_en_q), .pin_edge(pin_edge),
  .rtc_match(rtc_match), .wr_fire(wr_fire), .mem_sel(mem_sel),
  .req_addr(req_addr), .req_wdata(req_wdata), .raw_q(raw_q), .mask_q(mask_q));

// File: tb/hib_ctrl_test.sv
module hib_ctrl_test;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1, slow_tick = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic wake_pin = 1'b0, rtc_match = 1'b0, low_batt = 1'b0;
  logic req_ready, rd_valid, reg_off, irq, clk_sel;
  logic [31:0] rd_data;
  int total = 0, bad = 0;
  int tick_cnt = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
    slow_tick <= (tick_cnt == 3);
  end

  hib_ctrl #(.WRITE_TICKS(3)) uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .slow_tick(slow_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .wake_pin(wake_pin), .rtc_match(rtc_match),
    .low_batt(low_batt), .reg_off(reg_off), .irq(irq), .clk_sel(clk_sel));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    idle(16);
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
    idle(1);
  endtask

  task automatic pulse_rtc();
    @(negedge clk); rtc_match = 1'b1;
    @(negedge clk); rtc_match = 1'b0;
    idle(2);
  endtask

  // Monitor: pops the expected read data when the response appears.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (exp_q.size() == 0) check("R2 unexpected response", rd_data, 32'hx);
        else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    por_n = 1'b1;
    idle(2);
    check("R1 reg_off", {31'b0, reg_off}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 clk_sel", {31'b0, clk_sel}, 0);
    rd(7'd2, 32'h0, "R1 raw");

    // R2 storage
    wr(7'd64, 32'hA5A5_0001);
    wr(7'd127, 32'h1234_5678);
    wr(7'd81, 32'hDEAD_BEEF);
    rd(7'd64, 32'hA5A5_0001, "R2 word0");
    rd(7'd127, 32'h1234_5678, "R2 word63");
    rd(7'd81, 32'hDEAD_BEEF, "R2 word17");

    // R4 hibernate without wake source
    wr(7'd0, 32'h1);
    check("R4 reg_off", {31'b0, reg_off}, 0);
    rd(7'd0, 32'h0, "R4 ctrl");

    // R10 clock select
    wr(7'd0, 32'h4);
    check("R10 clk_sel", {31'b0, clk_sel}, 1);
    rd(7'd0, 32'h4, "R10 ctrl");
    wr(7'd0, 32'h0);
    check("R10 clk_sel low", {31'b0, clk_sel}, 0);

    // R11 write inside busy window dropped
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'd69; req_wdata = 32'hAAAA_0000;
    @(negedge clk);
    req_wdata = 32'hBBBB_1111;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    idle(16);
    rd(7'd69, 32'hAAAA_0000, "R11 dropped write");

    // R7 events
    pulse_rtc();
    rd(7'd2, 32'h1, "R7 rtc bit");
    @(negedge clk); low_batt = 1'b1;
    @(negedge clk); low_batt = 1'b0;
    idle(2);
    rd(7'd2, 32'h3, "R7 batt bit");
    @(negedge clk); wake_pin = 1'b1;
    idle(6);
    rd(7'd2, 32'h7, "R7 pin bit");

    // R8 masked view
    wr(7'd1, 32'h2);
    rd(7'd3, 32'h2, "R8 mis");
    check("R8 irq on", {31'b0, irq}, 1);
    wr(7'd1, 32'h0);
    check("R8 irq off", {31'b0, irq}, 0);

    // R9 clear, R7 pin held high sets once
    wr(7'd4, 32'h4);
    rd(7'd2, 32'h3, "R7 pin held once");
    wr(7'd4, 32'h0);
    rd(7'd2, 32'h3, "R9 zero write no effect");
    wr(7'd4, 32'h3);
    rd(7'd2, 32'h0, "R9 clear");
    @(negedge clk); wake_pin = 1'b0;
    idle(4);

    // R3/R5/R6/R12 pin wake
    wr(7'd1, 32'h7);
    wr(7'd0, 32'h9);
    check("R3 reg_off", {31'b0, reg_off}, 1);
    rd(7'd0, 32'h9, "R3 ctrl");
    @(negedge clk); sys_rst_n = 1'b0;
    pulse_rtc();
    check("R6 rtc ignored", {31'b0, reg_off}, 1);
    @(negedge clk); wake_pin = 1'b1;
    idle(5);
    check("R5 reg_off", {31'b0, reg_off}, 0);
    @(negedge clk); sys_rst_n = 1'b1;
    idle(2);
    rd(7'd2, 32'h5, "R5 raw kept");
    rd(7'd0, 32'h8, "R12 ctrl kept");
    rd(7'd1, 32'h0, "R12 mask cleared");
    rd(7'd64, 32'hA5A5_0001, "R12 storage kept");
    @(negedge clk); wake_pin = 1'b0;
    idle(4);

    // R6 RTC wake
    wr(7'd4, 32'h7);
    wr(7'd0, 32'h3);
    check("R3 rtc armed", {31'b0, reg_off}, 1);
    @(negedge clk); wake_pin = 1'b1;
    idle(5);
    check("R6 pin ignored", {31'b0, reg_off}, 1);
    pulse_rtc();
    check("R6 rtc wake", {31'b0, reg_off}, 0);
    rd(7'd0, 32'h2, "R6 ctrl");
    @(negedge clk); wake_pin = 1'b0;

    idle(4);
    check("R2 responses drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule